// File: doc/BRIEF.md
# Reloadable Interval and Watchdog Timer

This block is a down-counting timer that answers as a slave on a simple strobe/acknowledge bus. Software writes one word that carries both a start value and a mode flag. While the external run enable is high, the count falls by one per clock. When it reaches zero, the timer does one of two things, depending on the mode flag:
- it stops there until software writes it again, or
- it reloads the start value and keeps running, so it fires periodically.

Each zero crossing produces a single-clock timeout pulse. The internal behaviour is the same whatever that pulse drives. It can go to a processor interrupt input. It can also go to a reset input, which turns the block into a watchdog.

The run enable is meant to be tied to the inverse of a processor halt. While the processor is stopped, the count is frozen. A synchronous reset clears the count and the mode, and leaves the timer disabled.

Top module: `reload_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count, the mode flag, `timeout` and `bus_ack` are all cleared. After reset the timer stays at zero until it is written.
- R2: A strobed write (`bus_cyc`, `bus_stb` and `bus_we` high) loads the count and the start value from `bus_wdata[30:0]`. It loads the mode flag from `bus_wdata[31]`, where 1 means auto-reload and 0 means one-shot. `bus_rdata` always shows the mode flag in bit 31 and the live count in bits 30:0.
- R3: At each clock edge where `run_en` is high, no write occurs and the count is above 1, the count drops by exactly one.
- R4: While `run_en` is low and no write occurs, the count holds its value and `timeout` stays low, even when the count is 1.
- R5: In one-shot mode the count goes from 1 to 0 and then stays at 0 until the next write.
- R6: In auto-reload mode, an edge that would take the count from 1 to 0 loads the start value instead. A start value S therefore produces one timeout every S running cycles.
- R7: `timeout` is high for exactly the one cycle that follows an edge where the count leaves 1 while running. It is low at every other time.
- R8: Writing a start value of 0 disables the timer in either mode. The count stays at 0 and no timeout is produced.
- R9: A write on the same edge as a zero crossing takes priority. The written value is loaded, no reload takes place, and no timeout pulse is produced.
- R10: `bus_ack` is high for one cycle after every strobed access, read or write, and is low otherwise. `bus_stall` is always low. A read does not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Count enable; low freezes the count |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable for the strobed access |
| bus_wdata | input | DATA_W | Write word: bit 31 mode, bits 30:0 start value |
| bus_ack | output | 1 | Acknowledge, one clock after a strobe |
| bus_stall | output | 1 | Stall, always low |
| bus_rdata | output | DATA_W | Mode flag and live count |
| timeout | output | 1 | One-clock pulse on each zero crossing |

## Verification
The properties assume that a write is never held for several cycles in a way that stops the counter from being observed. They also assume that `run_en` and the bus inputs change only between clock edges, and that reset is applied synchronously. The stimulus drives every input at the falling edge and keeps each strobe one cycle long. It sweeps small start values in both modes with the run enable held high, and compares the count and the timeout against arithmetic over the number of elapsed cycles. Separate sequences gate the run enable off at an intermediate count and at a count of 1. Other sequences place a write exactly on a crossing edge and assert reset in the middle of a run.

// File: rtl/timer_pkg.sv
package timer_pkg;

    // Behaviour on reaching zero, taken from the top bit of a written word
    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_RELOAD  = 1'b1
    } timer_mode_e;

endpackage

// File: rtl/timer_busif.sv
module timer_busif #(
    parameter int DATA_W = 32,
    localparam int CNT_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cur_count,
    input  logic              cur_mode,
    output logic              wr_en,
    output logic              wr_mode,
    output logic [CNT_W-1:0]  wr_value,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [DATA_W-1:0] bus_rdata
);

    typedef struct packed {
        logic ack;
    } busif_state_t;

    busif_state_t st_d, st_q;
    logic         strobe;

    always_comb begin
        strobe   = bus_cyc && bus_stb;
        wr_en    = strobe && bus_we;
        wr_mode  = bus_wdata[DATA_W-1];
        wr_value = bus_wdata[CNT_W-1:0];
        st_d     = st_q;
        st_d.ack = strobe;
        if (rst) begin
            st_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bus_ack   = st_q.ack;
    assign bus_stall = 1'b0;
    assign bus_rdata = {cur_mode, cur_count};

endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
#(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             wr_en,
    input  logic             wr_mode,
    input  logic [CNT_W-1:0] wr_value,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] start_val,
    output logic             mode,
    output logic             timeout
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] start;
        timer_mode_e      mode;
        logic             timeout;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.timeout = 1'b0;
        if (rst) begin
            st_d.count = '0;
            st_d.start = '0;
            st_d.mode  = MODE_ONESHOT;
        end else if (wr_en) begin
            // a write beats any crossing on the same edge
            st_d.count = wr_value;
            st_d.start = wr_value;
            st_d.mode  = timer_mode_e'(wr_mode);
        end else if (run_en && (st_q.count != '0)) begin
            if (st_q.count == CNT_ONE) begin
                st_d.timeout = 1'b1;
                st_d.count   = (st_q.mode == MODE_RELOAD) ? st_q.start : '0;
            end else begin
                st_d.count = st_q.count - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count     = st_q.count;
    assign start_val = st_q.start;
    assign mode      = st_q.mode;
    assign timeout   = st_q.timeout;

endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
    parameter int DATA_W = 32,
    localparam int CNT_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timeout
);

    logic             wr_en;
    logic             wr_mode;
    logic [CNT_W-1:0] wr_value;
    logic [CNT_W-1:0] cur_count;
    logic [CNT_W-1:0] start_val;
    logic             cur_mode;

    timer_busif #(.DATA_W(DATA_W)) u_busif (
        .clk       (clk),
        .rst       (rst),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cur_count (cur_count),
        .cur_mode  (cur_mode),
        .wr_en     (wr_en),
        .wr_mode   (wr_mode),
        .wr_value  (wr_value),
        .bus_ack   (bus_ack),
        .bus_stall (bus_stall),
        .bus_rdata (bus_rdata)
    );

    timer_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .wr_en     (wr_en),
        .wr_mode   (wr_mode),
        .wr_value  (wr_value),
        .count     (cur_count),
        .start_val (start_val),
        .mode      (cur_mode),
        .timeout   (timeout)
    );

endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
    parameter int DATA_W = 32,
    localparam int CNT_W = DATA_W - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic              bus_cyc,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              timeout,
    input logic [CNT_W-1:0]  start_val
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             wr;
    logic             stb;
    logic [CNT_W-1:0] cnt;
    logic             mode_bit;
    logic             crossing;

    assign stb      = bus_cyc && bus_stb;
    assign wr       = stb && bus_we;
    assign cnt      = bus_rdata[CNT_W-1:0];
    assign mode_bit = bus_rdata[DATA_W-1];
    assign crossing = run_en && !wr && (cnt == CNT_ONE);

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr |=> bus_rdata == $past(bus_wdata)); // R2

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (run_en && !wr && cnt > CNT_ONE) |=> cnt == $past(cnt) - CNT_ONE); // R3

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !wr) |=> ($stable(bus_rdata) && !timeout)); // R4

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (crossing && !mode_bit) |=> cnt == '0); // R5

    AST_RELOAD_START: assert property (@(posedge clk) disable iff (rst)
        (crossing && mode_bit) |=> cnt == start_val); // R6

    AST_PULSE_ON_CROSS: assert property (@(posedge clk) disable iff (rst)
        crossing |=> timeout); // R7

    AST_NO_PULSE_ELSE: assert property (@(posedge clk) disable iff (rst)
        !crossing |=> !timeout); // R9

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!wr && cnt == '0) |=> cnt == '0); // R8

    AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        stb |=> bus_ack); // R10

    AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
        !stb |=> !bus_ack); // R10

endmodule

bind reload_timer timer_checker #(.DATA_W(DATA_W)) u_timer_checker (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .timeout   (timeout),
    .start_val (start_val)
);

// File: tb/test_reload_timer.sv
module test_reload_timer;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int MAX_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic          bus_cyc = 1'b0;
    logic          bus_stb = 1'b0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_ack;
    logic          bus_stall;
    logic [DW-1:0] bus_rdata;
    logic          timeout;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_timer #(.DATA_W(DW)) i_reload_timer (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_stall (bus_stall),
        .bus_rdata (bus_rdata),
        .timeout   (timeout)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic chk_state(input string req, input logic [31:0] exp_rd, input logic exp_to);
        chk(bus_rdata == exp_rd, req, bus_rdata, exp_rd);
        chk(timeout == exp_to, {req, " timeout"}, 32'(timeout), 32'(exp_to));
    endtask

    function automatic logic [30:0] exp_cnt(input bit m, input int s, input int k);
        if (s == 0) return '0;
        if (!m) return (k >= s) ? 31'd0 : 31'(s - k);
        return 31'(s - (k % s));
    endfunction

    function automatic bit exp_to(input bit m, input int s, input int k);
        if (s == 0 || k == 0) return 1'b0;
        return m ? (k % s == 0) : (k == s);
    endfunction

    // drive a one-cycle write; returns at the falling edge after the write edge
    task automatic bus_write(input logic [31:0] word);
        bus_cyc   = 1'b1;
        bus_stb   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = word;
        @(negedge clk);
        bus_cyc = 1'b0;
        bus_stb = 1'b0;
        bus_we  = 1'b0;
    endtask

    always @(posedge clk) cycles++;

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk_state("R1 reset", 32'h0, 1'b0);
        chk(bus_ack == 1'b0, "R1 ack", 32'(bus_ack), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        chk_state("R1 idle after reset", 32'h0, 1'b0);

        // R2 R3 R5 R6 R7 R8 R10: sweep small start values in both modes
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 8; s++) begin
                run_en = 1'b1;
                bus_write({m[0], 31'(s)});
                chk(bus_ack == 1'b1, "R10 ack after write", 32'(bus_ack), 32'h1);
                chk(bus_stall == 1'b0, "R10 stall", 32'(bus_stall), 32'h0);
                chk_state("R2 load", {m[0], exp_cnt(m[0], s, 0)}, 1'b0);
                for (int k = 1; k <= 20; k++) begin
                    @(negedge clk);
                    if (k == 1) chk(bus_ack == 1'b0, "R10 ack drop", 32'(bus_ack), 32'h0);
                    chk_state(s == 0 ? "R8 disabled" : (m == 1 ? "R6 reload" : "R5 one-shot"),
                              {m[0], exp_cnt(m[0], s, k)}, exp_to(m[0], s, k));
                end
            end
        end

        // R4: hold at an intermediate count
        bus_write({1'b0, 31'd10});
        for (int k = 1; k <= 3; k++) @(negedge clk);
        run_en = 1'b0;
        chk_state("R3 before hold", 32'd7, 1'b0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk_state("R4 hold", 32'd7, 1'b0);
        end
        run_en = 1'b1;
        @(negedge clk);
        chk_state("R3 resume", 32'd6, 1'b0);

        // R4: hold at 1 gives no timeout, then R5/R7 crossing
        bus_write({1'b0, 31'd2});
        @(negedge clk);
        run_en = 1'b0;
        chk_state("R3 count 1", 32'd1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk_state("R4 hold at one", 32'd1, 1'b0);
        end
        run_en = 1'b1;
        @(negedge clk);
        chk_state("R7 pulse", 32'd0, 1'b1);
        @(negedge clk);
        chk_state("R5 stays zero", 32'd0, 1'b0);

        // R9: write on a crossing edge, reload mode
        bus_write({1'b1, 31'd3});
        @(negedge clk);
        @(negedge clk);
        chk_state("R9 setup", {1'b1, 31'd1}, 1'b0);
        bus_write({1'b1, 31'd5});
        chk_state("R9 write wins", {1'b1, 31'd5}, 1'b0);
        @(negedge clk);
        chk_state("R9 continue", {1'b1, 31'd4}, 1'b0);

        // R9: write on a crossing edge, one-shot mode
        bus_write({1'b0, 31'd2});
        @(negedge clk);
        bus_write({1'b0, 31'd4});
        chk_state("R9 one-shot write wins", 32'd4, 1'b0);

        // R10: read access acks and leaves the count alone
        run_en  = 1'b0;
        bus_cyc = 1'b1;
        bus_stb = 1'b1;
        bus_we  = 1'b0;
        @(negedge clk);
        bus_cyc = 1'b0;
        bus_stb = 1'b0;
        chk(bus_ack == 1'b1, "R10 read ack", 32'(bus_ack), 32'h1);
        chk_state("R10 read no change", 32'd4, 1'b0);
        bus_cyc = 1'b1;
        @(negedge clk);
        bus_cyc = 1'b0;
        chk(bus_ack == 1'b0, "R10 no ack without strobe", 32'(bus_ack), 32'h0);
        chk(bus_stall == 1'b0, "R10 stall low", 32'(bus_stall), 32'h0);

        // R1: reset in the middle of a reload run
        run_en = 1'b1;
        bus_write({1'b1, 31'd5});
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_state("R1 mid-run reset", 32'h0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk_state("R1 disabled after reset", 32'h0, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, MAX_CYCLES);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule